// File: doc/BRIEF.md
# Rotate-and-Mask Integer Execution Unit

This execution unit carries out a 32-bit "rotate left by an immediate amount, then keep a masked run of bits" operation. It receives a 32-bit instruction word, the 64-bit value of the source register and the current summary-overflow bit. It splits the word into its fields, rotates the low half of the source left and ANDs the rotated word with a mask. The mask is built from a begin position and an end position, both counted from the most significant bit. The result is zero-extended to 64 bits and comes out together with the destination register index and a write enable.

When the record flag is set, the unit also produces a 4-bit condition field with its own enable. The field reports whether the 32-bit result, read as a signed number, is below, above or equal to zero, and it carries the summary-overflow bit. The common shift idioms are all forms of this one operation: logical left shift, logical right shift, clearing the high bits and clearing the low bits. The unit has a single register stage. A valid strobe samples the inputs, and the results appear on the next clock as single-cycle pulses.

Top module: `rotmask_exec_unit`

## Requirements
- R1: The instruction word is numbered MSB-first, so word bit 0 is `instr_word[31]`. `instr_word[31:26]` is the opcode, `[25:21]` the source index, `[20:16]` the destination index, `[15:11]` the rotate amount, `[10:6]` the mask begin, `[5:1]` the mask end and `[0]` the record flag. The destination index is reported on `out_dest_idx`.
- R2: Only opcode 21 (base word 0x54000000) is legal. Any other opcode gives `out_illegal`=1 for one cycle, with `out_dest_we`=0 and `out_cond_we`=0.
- R3: Only the low 32 bits of `src_value` are rotated left, by 0 to 31 places. Bits 63:32 of the source have no effect on the result.
- R4: When begin ≤ end, the mask has ones exactly at positions begin through end, where position 0 is bit 31 of the word.
- R5: When begin > end, the mask is all ones except positions end+1 through begin−1.
- R6: `out_dest_value[63:32]` is always zero, and `out_dest_value[31:0]` is the rotated word ANDed with the mask.
- R7: With the record flag at 1, `out_cond_we` pulses with `out_cond` = {LT, GT, EQ, SO}: bit 3 means the result is negative as a signed number, bit 2 positive, bit 1 zero, and bit 0 is a copy of `so_in`. With the record flag at 0, `out_cond_we` stays 0.
- R8: Rotate n with begin 0 and end 31−n gives a logical left shift by n. Rotate 32−n with begin n and end 31 gives a logical right shift by n. Rotate 0 with begin n and end 31 clears the top n bits. Rotate 0 with begin 0 and end 31−n clears the low n bits.
- R9: Outputs are registered. Enables and `out_illegal` rise on the clock after the cycle in which `in_valid` is high, and they last exactly one cycle. Without `in_valid` they stay at 0.
- R10: A synchronous active-high `rst` clears every output to zero.
- R11: When begin = end+1 (modulo 32), the mask is all ones. When begin = end, the mask has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Samples the instruction and operands |
| instr_word | input | 32 | Instruction word |
| src_value | input | 64 | Source register value |
| so_in | input | 1 | Summary-overflow bit copied into the condition field |
| out_dest_value | output | 64 | Zero-extended masked result |
| out_dest_idx | output | 5 | Destination register index |
| out_dest_we | output | 1 | Destination write pulse |
| out_cond | output | 4 | Condition field {LT, GT, EQ, SO} |
| out_cond_we | output | 1 | Condition field write pulse |
| out_illegal | output | 1 | Unrecognised opcode pulse |

## Verification
The unit holds no state beyond its single output stage. Any fault in decode, rotation or mask building therefore shows as a wrong `out_dest_value` or `out_cond` on the cycle right after the strobe, with no latency to hide it. A mask fault only shows when the rotated word has ones at the wrong positions, so the stimulus uses all-ones and dense operands around the begin/end boundaries. A fault in the enable logic shows as a pulse that is missing, comes late or lasts two cycles, and this is visible one cycle after `in_valid`.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;
  localparam int OPC_W = 6;
  localparam int IDX_W = 5;

  // Field layout: the word's MSB-first bit 0 sits at the struct's top
  typedef struct packed {
    logic [OPC_W-1:0] opc;
    logic [IDX_W-1:0] src_idx;
    logic [IDX_W-1:0] dst_idx;
    logic [IDX_W-1:0] rot_amt;
    logic [IDX_W-1:0] mask_lo_pos;
    logic [IDX_W-1:0] mask_hi_pos;
    logic             rec;
  } mform_fields_t;

  // Condition flag positions inside the 4-bit field
  localparam int CF_LT = 3;
  localparam int CF_GT = 2;
  localparam int CF_EQ = 1;
  localparam int CF_SO = 0;
endpackage

// File: rtl/rotmask_decode.sv
module rotmask_decode
  import rotmask_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int OPC_VAL = 21
) (
  input  logic [INSTR_W-1:0] instr,
  output mform_fields_t      fields,
  output logic               legal
);
  always_comb begin
    fields = mform_fields_t'(instr);
    legal  = (fields.opc == OPC_W'(OPC_VAL));
  end
endmodule

// File: rtl/rotmask_rotator.sv
module rotmask_rotator #(
  parameter int W = 32,
  localparam int SH_W = $clog2(W)
) (
  input  logic [W-1:0]    din,
  input  logic [SH_W-1:0] amt,
  output logic [W-1:0]    dout
);
  logic [W-1:0] stage [SH_W+1];

  assign stage[0] = din;

  // Log-depth barrel: stage s rotates by 2**s when amt[s] is set
  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage[s+1] = amt[s] ? {stage[s][W-1-STEP:0], stage[s][W-1:W-STEP]}
                               : stage[s];
  end

  assign dout = stage[SH_W];
endmodule

// File: rtl/rotmask_maskgen.sv
module rotmask_maskgen #(
  parameter int W = 32,
  localparam int SH_W = $clog2(W)
) (
  input  logic [SH_W-1:0] lo_pos,
  input  logic [SH_W-1:0] hi_pos,
  output logic [W-1:0]    mask
);
  logic wraps;
  assign wraps = (lo_pos > hi_pos);

  // Position p counts from the MSB, so it lands on bit index W-1-p
  for (genvar p = 0; p < W; p++) begin : g_pos
    localparam logic [SH_W-1:0] POS = SH_W'(p);
    logic at_or_after_lo, at_or_before_hi;
    assign at_or_after_lo  = (POS >= lo_pos);
    assign at_or_before_hi = (POS <= hi_pos);
    assign mask[W-1-p] = wraps ? (at_or_after_lo | at_or_before_hi)
                               : (at_or_after_lo & at_or_before_hi);
  end
endmodule

// File: rtl/rotmask_exec_unit.sv
module rotmask_exec_unit
  import rotmask_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int WORD_W  = 32,
  parameter int INSTR_W = 32,
  parameter int OPC_VAL = 21
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [INSTR_W-1:0] instr_word,
  input  logic [XLEN-1:0]    src_value,
  input  logic               so_in,
  output logic [XLEN-1:0]    out_dest_value,
  output logic [IDX_W-1:0]   out_dest_idx,
  output logic               out_dest_we,
  output logic [3:0]         out_cond,
  output logic               out_cond_we,
  output logic               out_illegal
);
  localparam int SH_W = $clog2(WORD_W);

  // Signed compare of a word against zero, packed as {LT, GT, EQ}
  function automatic logic [2:0] cmp_zero(input logic [WORD_W-1:0] w);
    logic is_zero, is_neg;
    is_zero = (w == '0);
    is_neg  = w[WORD_W-1];
    return {is_neg, !is_neg && !is_zero, is_zero};
  endfunction

  mform_fields_t     dec_fields;
  logic              dec_legal;
  logic [SH_W-1:0]   dbg_lo_pos, dbg_hi_pos;
  logic [WORD_W-1:0] rot_word, mask_word, masked_word;
  logic [2:0]        cmp_flags;

  rotmask_decode #(.INSTR_W(INSTR_W), .OPC_VAL(OPC_VAL)) u_decode (
    .instr (instr_word),
    .fields(dec_fields),
    .legal (dec_legal)
  );

  assign dbg_lo_pos = SH_W'(dec_fields.mask_lo_pos);
  assign dbg_hi_pos = SH_W'(dec_fields.mask_hi_pos);

  rotmask_rotator #(.W(WORD_W)) u_rotator (
    .din (src_value[WORD_W-1:0]),
    .amt (SH_W'(dec_fields.rot_amt)),
    .dout(rot_word)
  );

  rotmask_maskgen #(.W(WORD_W)) u_maskgen (
    .lo_pos(dbg_lo_pos),
    .hi_pos(dbg_hi_pos),
    .mask  (mask_word)
  );

  assign masked_word = rot_word & mask_word;
  assign cmp_flags   = cmp_zero(masked_word);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_dest_value <= '0;
      out_dest_idx   <= '0;
      out_dest_we    <= 1'b0;
      out_cond       <= '0;
      out_cond_we    <= 1'b0;
      out_illegal    <= 1'b0;
    end else begin
      out_dest_we <= in_valid && dec_legal;
      out_cond_we <= in_valid && dec_legal && dec_fields.rec;
      out_illegal <= in_valid && !dec_legal;
      if (in_valid && dec_legal) begin
        out_dest_value <= XLEN'(masked_word);
        out_dest_idx   <= dec_fields.dst_idx;
        if (dec_fields.rec) begin
          out_cond <= {cmp_flags, so_in};
        end
      end
    end
  end
endmodule

// File: rtl/rotmask_checker.sv
module rotmask_checker #(
  parameter int XLEN    = 64,
  parameter int WORD_W  = 32,
  parameter int INSTR_W = 32,
  parameter int OPC_VAL = 21,
  localparam int SH_W = $clog2(WORD_W)
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [INSTR_W-1:0] instr_word,
  input logic               so_in,
  input logic [XLEN-1:0]    out_dest_value,
  input logic [4:0]         out_dest_idx,
  input logic               out_dest_we,
  input logic [3:0]         out_cond,
  input logic               out_cond_we,
  input logic               out_illegal,
  input logic [SH_W-1:0]    lo_pos,
  input logic [SH_W-1:0]    hi_pos,
  input logic [WORD_W-1:0]  mask_word
);
  logic opc_ok;
  assign opc_ok = (instr_word[INSTR_W-1 -: 6] == 6'(OPC_VAL));

  AST_DEST_IDX: assert property (@(posedge clk) disable iff (rst)
    in_valid && opc_ok |=> out_dest_idx == $past(instr_word[20:16])); // R1
  AST_LEGAL_WRITES: assert property (@(posedge clk) disable iff (rst)
    in_valid && opc_ok |=> out_dest_we && !out_illegal); // R2
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> !out_dest_we && !out_cond_we); // R2
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    out_dest_we |-> out_dest_value[XLEN-1:WORD_W] == '0); // R6
  AST_COND_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
    out_cond_we |-> $countones(out_cond[3:1]) == 1); // R7
  AST_COND_EQ: assert property (@(posedge clk) disable iff (rst)
    out_cond_we |-> out_cond[1] == (out_dest_value[WORD_W-1:0] == '0)); // R7
  AST_COND_SO: assert property (@(posedge clk) disable iff (rst)
    in_valid && opc_ok && instr_word[0] |=> out_cond_we && out_cond[0] == $past(so_in)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_dest_we && !out_cond_we && !out_illegal); // R9
  AST_MASK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    lo_pos == hi_pos |-> $countones(mask_word) == 1); // R11
  AST_MASK_FULL: assert property (@(posedge clk) disable iff (rst)
    lo_pos == SH_W'(hi_pos + 1'b1) |-> &mask_word); // R11
endmodule

bind rotmask_exec_unit rotmask_checker #(
  .XLEN(XLEN), .WORD_W(WORD_W), .INSTR_W(INSTR_W), .OPC_VAL(OPC_VAL)
) u_rotmask_checker (
  .clk(clk), .rst(rst), .in_valid(in_valid), .instr_word(instr_word),
  .so_in(so_in), .out_dest_value(out_dest_value), .out_dest_idx(out_dest_idx),
  .out_dest_we(out_dest_we), .out_cond(out_cond), .out_cond_we(out_cond_we),
  .out_illegal(out_illegal), .lo_pos(dbg_lo_pos), .hi_pos(dbg_hi_pos),
  .mask_word(mask_word)
);

// File: tb/test_rotmask_exec_unit.sv
module test_rotmask_exec_unit;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [4:0]  sh;
    logic [4:0]  mb;
    logic [4:0]  me;
    logic        rc;
    logic [4:0]  ra;
    logic [63:0] src;
    logic        so;
    logic [31:0] exp;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{5'd4,  5'd0,  5'd27, 1'b0, 5'd3,  64'hDEAD_BEEF_1234_5678, 1'b0, 32'h2345_6780}, // R8 left shift, R3 upper ignored
    '{5'd24, 5'd8,  5'd31, 1'b1, 5'd5,  64'h0000_0000_1234_5678, 1'b0, 32'h0012_3456}, // R8 right shift
    '{5'd0,  5'd16, 5'd31, 1'b1, 5'd7,  64'h0000_0000_1234_5678, 1'b1, 32'h0000_5678}, // R8 clear high
    '{5'd0,  5'd0,  5'd23, 1'b0, 5'd9,  64'h0000_0000_1234_5678, 1'b0, 32'h1234_5600}, // R8 clear low
    '{5'd0,  5'd31, 5'd31, 1'b1, 5'd11, 64'h0000_0000_FFFF_FFFF, 1'b0, 32'h0000_0001}, // R11 single lsb
    '{5'd0,  5'd31, 5'd0,  1'b1, 5'd13, 64'h0000_0000_FFFF_FFFF, 1'b0, 32'h8000_0001}, // R5 wrap
    '{5'd8,  5'd0,  5'd31, 1'b1, 5'd15, 64'h0000_0000_8000_0000, 1'b0, 32'h0000_0080}, // R4 full rotate
    '{5'd16, 5'd5,  5'd4,  1'b1, 5'd17, 64'h0000_0000_0000_ABCD, 1'b0, 32'hABCD_0000}, // R11 wrap all ones
    '{5'd0,  5'd0,  5'd31, 1'b1, 5'd19, 64'hFFFF_FFFF_0000_0000, 1'b1, 32'h0000_0000}, // R7 zero result
    '{5'd1,  5'd0,  5'd0,  1'b1, 5'd31, 64'h0000_0000_4000_0000, 1'b0, 32'h8000_0000}  // R11 single msb
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr_word = '0;
  logic [63:0] src_value = '0;
  logic        so_in = 1'b0;
  logic [63:0] out_dest_value;
  logic [4:0]  out_dest_idx;
  logic        out_dest_we;
  logic [3:0]  out_cond;
  logic        out_cond_we;
  logic        out_illegal;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rotmask_exec_unit i_rotmask_exec_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr_word(instr_word),
    .src_value(src_value), .so_in(so_in), .out_dest_value(out_dest_value),
    .out_dest_idx(out_dest_idx), .out_dest_we(out_dest_we), .out_cond(out_cond),
    .out_cond_we(out_cond_we), .out_illegal(out_illegal)
  );

  function automatic logic [31:0] mk_word(input logic [5:0] opc, input logic [4:0] ra,
      input logic [4:0] sh, input logic [4:0] mb, input logic [4:0] me, input logic rc);
    return {opc, 5'd1, ra, sh, mb, me, rc};
  endfunction

  // Model: result bit i takes source bit (i - sh) mod 32; MSB-first position p
  // is kept when its distance from begin does not exceed the begin-to-end span
  function automatic logic [31:0] model(input logic [31:0] s, input int sh,
      input int mb, input int me);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      int p;
      p = 31 - i;
      r[i] = (((p - mb + 32) % 32) <= ((me - mb + 32) % 32)) ? s[(i - sh + 32) % 32] : 1'b0;
    end
    return r;
  endfunction

  function automatic logic [3:0] exp_cond(input logic [31:0] r, input logic so);
    return {$signed(r) < 0, $signed(r) > 0, r == 0, so};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
      input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one strobe, then sample the registered outputs one cycle later
  task automatic issue(input logic [31:0] w, input logic [63:0] s, input logic so);
    @(negedge clk);
    instr_word = w; src_value = s; so_in = so; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_legal(input logic [4:0] sh, input logic [4:0] mb, input logic [4:0] me,
      input logic rc, input logic [4:0] ra, input logic [63:0] s, input logic so,
      input logic [31:0] exp, input string req);
    logic [63:0] e64;
    e64 = {32'h0, exp};
    issue(mk_word(6'd21, ra, sh, mb, me, rc), s, so);
    check(out_dest_value == e64, req, out_dest_value, e64);
    check(out_dest_we && out_dest_idx == ra && !out_illegal, {req, " R1 R9 we/idx"},
          {out_dest_we, out_illegal, out_dest_idx}, {1'b1, 1'b0, ra});
    check(out_cond_we == rc, {req, " R7 cond_we"}, out_cond_we, rc);
    if (rc) check(out_cond == exp_cond(exp, so), {req, " R7 cond"}, out_cond, exp_cond(exp, so));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: outputs zero while in reset
    check(out_dest_value == 0 && out_dest_idx == 0 && !out_dest_we && out_cond == 0
          && !out_cond_we && !out_illegal, "R10 reset state", out_dest_value, 0);
    rst = 1'b0;

    for (int k = 0; k < NVEC; k++) begin
      run_legal(VECS[k].sh, VECS[k].mb, VECS[k].me, VECS[k].rc, VECS[k].ra,
                VECS[k].src, VECS[k].so, VECS[k].exp, "R4 R5 R6 R8 table");
    end

    // R9: pulses last one cycle
    run_legal(5'd3, 5'd0, 5'd31, 1'b1, 5'd2, 64'h1, 1'b0, 32'h8, "R9 pulse");
    @(negedge clk);
    check(!out_dest_we && !out_cond_we && !out_illegal, "R9 pulse drop",
          {out_dest_we, out_cond_we, out_illegal}, 0);

    // R2: illegal opcode
    issue(mk_word(6'd31, 5'd4, 5'd0, 5'd0, 5'd31, 1'b1), 64'h1234, 1'b1);
    check(out_illegal && !out_dest_we && !out_cond_we, "R2 illegal opcode",
          {out_illegal, out_dest_we, out_cond_we}, 3'b100);
    issue(mk_word(6'd20, 5'd4, 5'd0, 5'd0, 5'd31, 1'b0), 64'h1234, 1'b0);
    check(out_illegal && !out_dest_we, "R2 neighbour opcode",
          {out_illegal, out_dest_we}, 2'b10);

    // R3: upper source bits have no effect
    run_legal(5'd0, 5'd0, 5'd31, 1'b1, 5'd6, 64'hFFFF_FFFF_0000_0001, 1'b0, 32'h1, "R3 upper ignored");

    // R1 R4 R5 R6 R7 R11: broad pseudo-random sweep against the bench model
    for (int k = 0; k < 300; k++) begin
      logic [4:0] sh, mb, me, ra;
      logic rc, so;
      logic [63:0] s;
      sh = 5'($urandom); mb = 5'($urandom); me = 5'($urandom); ra = 5'($urandom);
      if (k % 7 == 0) me = mb;
      if (k % 11 == 0) mb = me + 5'd1;
      rc = 1'($urandom); so = 1'($urandom);
      s = {$urandom, $urandom};
      if (k % 5 == 0) s[31:0] = 32'hFFFF_FFFF;
      run_legal(sh, mb, me, rc, ra, s, so, model(s[31:0], int'(sh), int'(mb), int'(me)),
                "R1 R4 R5 R11 sweep");
    end

    // R10: reset mid-run clears held outputs
    issue(mk_word(6'd21, 5'd9, 5'd0, 5'd0, 5'd31, 1'b1), 64'hFFFF_FFFF, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    check(out_dest_value == 0 && out_cond == 0 && out_dest_idx == 0 && !out_dest_we,
          "R10 reset clears", out_dest_value, 0);
    rst = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule